// File: doc/BRIEF.md
# Boot Memory Alias Decoder

This block sits on the address path of a processor bus. It splits a 256 MB internal region into 1 MB areas and turns each request into one chip select for ROM, Flash or SRAM. It also produces the offset to present to the selected memory. A request to any area above the three fixed memories gets an abort response instead of a select.

The lowest area is an alias, so the exception vectors at the bottom of the map can come from different memories. After reset the alias shows the ROM or the Flash. The choice follows a boot flag that is loaded from the non-volatile boot-select input while reset is held. An erase strobe clears that flag. A one written to the command bit of the remap control register swaps the alias over to SRAM, which lets software install its own vectors. A second such write swaps it back to the reset mapping.

Whatever memory the alias shows can still be reached at its own fixed area. Selects and offset are combinational from the request. Only the remap state and the boot flag are registers.

Top module: `boot_alias_decoder`

## Requirements
- R1: Area index is `req_addr[27:20]`. With `req_valid` high, area 1 selects Flash, area 2 selects SRAM and area 3 selects ROM, whatever the remap state and boot flag are.
- R2: With `req_valid` high, any area index of 4 or more raises `abort`, drives no select and drives `mem_offset` to zero.
- R3: While `rst_n` is low, the remap state is cleared and the boot flag takes the value of `boot_sel_nv`. Without remap, area 0 selects ROM when the flag is 0 and Flash when it is 1.
- R4: A cycle with `erase` high clears the boot flag. From the next cycle on, area 0 selects ROM unless remap is active.
- R5: A cycle with `ctl_wr` high and `ctl_wdata[0]` set inverts the remap state from the next cycle on. While remap is active, area 0 selects SRAM. A second such write restores the reset mapping.
- R6: A cycle with `ctl_wr` high and `ctl_wdata[0]` clear leaves the remap state unchanged, whatever the other data bits hold.
- R7: `mem_offset` is `req_addr[19:0]` reduced modulo the size of the selected memory (defaults: ROM 64 KB, Flash 512 KB, SRAM 32 KB). For area 0, the size used is that of the aliased memory.
- R8: With `req_valid` high, exactly one of `sel_rom`, `sel_flash`, `sel_sram`, `abort` is high. With `req_valid` low, all four are low and `mem_offset` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus request present |
| req_addr | input | 28 | Byte address inside the internal region |
| ctl_wr | input | 1 | Write strobe for the remap control register |
| ctl_wdata | input | 32 | Write data; bit 0 is the remap command |
| boot_sel_nv | input | 1 | Non-volatile boot-select value, loaded during reset |
| erase | input | 1 | Erase strobe, clears the boot flag |
| sel_rom | output | 1 | ROM chip select |
| sel_flash | output | 1 | Flash chip select |
| sel_sram | output | 1 | SRAM chip select |
| abort | output | 1 | Unmapped-area abort |
| mem_offset | output | 20 | Offset inside the selected memory |

## Verification
The assertions assume that `boot_sel_nv` is stable while reset is held. They also assume that `req_addr` is a known value whenever `req_valid` is high. The stimulus changes inputs only at falling clock edges. It sets `boot_sel_nv` before reset goes low and keeps it unchanged until the next reset. Command writes and erase strobes last one cycle each. Each is followed by a request that shows its effect.

// File: rtl/boot_map_pkg.sv
// Package: shared types and fixed area numbering for the boot alias decoder.
// Assumes 1 MB areas; the area order below is fixed by the memory map.
package boot_map_pkg;

    // Target chosen for one bus request.
    typedef enum logic [2:0] {
        TGT_IDLE  = 3'd0,
        TGT_ROM   = 3'd1,
        TGT_FLASH = 3'd2,
        TGT_SRAM  = 3'd3,
        TGT_ABORT = 3'd4
    } target_e;

    // Bits of address inside one area (1 MB).
    localparam int AREA_LSB = 20;

    // Fixed area numbers.
    localparam int AREA_ALIAS = 0;
    localparam int AREA_FLASH = 1;
    localparam int AREA_SRAM  = 2;
    localparam int AREA_ROM   = 3;

    // Index of each memory in per-memory arrays.
    localparam int MEM_ROM   = 0;
    localparam int MEM_FLASH = 1;
    localparam int MEM_SRAM  = 2;
    localparam int MEM_COUNT = 3;

endpackage

// File: rtl/remap_state.sv
// Module: remap_state
// Holds the remap toggle and the boot flag.
// Assumes boot_sel_nv is stable while rst_n is low; reset is synchronous, active low.
module remap_state #(
    parameter int DATA_W  = 32,
    parameter int CMD_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic              boot_sel_nv,
    input  logic              erase,
    output logic              remap_q,
    output logic              boot_q
);

    logic toggle_req;
    logic unused_wdata;

    // Only the command bit has meaning; the other bits are dropped.
    assign toggle_req   = ctl_wr && ctl_wdata[CMD_BIT];
    assign unused_wdata = ^ctl_wdata;

    // Remap flag: cleared by reset, inverted by each command write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remap_q <= 1'b0;
        end else if (toggle_req) begin
            remap_q <= ~remap_q;
        end
    end

    // Boot flag: loaded from the non-volatile bit during reset, cleared by erase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_q <= boot_sel_nv;
        end else if (erase) begin
            boot_q <= 1'b0;
        end
    end

endmodule

// File: rtl/area_decode.sv
// Module: area_decode
// Maps the area field of a request to a target memory or an abort.
// Assumes the address is relative to the base of the internal region.
module area_decode
    import boot_map_pkg::*;
#(
    parameter int ADDR_W = 28
) (
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              remap_q,
    input  logic              boot_q,
    output target_e           target
);

    localparam int AREA_W = ADDR_W - AREA_LSB;

    logic [AREA_W-1:0] area;
    target_e           alias_tgt;

    assign area = req_addr[ADDR_W-1:AREA_LSB];

    // Choose the memory that area 0 mirrors.
    always_comb begin
        if (remap_q) begin
            alias_tgt = TGT_SRAM;
        end else if (boot_q) begin
            alias_tgt = TGT_FLASH;
        end else begin
            alias_tgt = TGT_ROM;
        end
    end

    // Decode the area field into one target.
    always_comb begin
        if (!req_valid) begin
            target = TGT_IDLE;
        end else begin
            case (area)
                AREA_W'(AREA_ALIAS): target = alias_tgt;
                AREA_W'(AREA_FLASH): target = TGT_FLASH;
                AREA_W'(AREA_SRAM):  target = TGT_SRAM;
                AREA_W'(AREA_ROM):   target = TGT_ROM;
                default:             target = TGT_ABORT;
            endcase
        end
    end

endmodule

// File: rtl/offset_fold.sv
// Module: offset_fold
// Reduces the in-area offset to the physical size of the selected memory.
// Assumes every memory size is a power of two no larger than one area.
module offset_fold
    import boot_map_pkg::*;
#(
    parameter int ROM_BYTES   = 65536,
    parameter int FLASH_BYTES = 524288,
    parameter int SRAM_BYTES  = 32768
) (
    input  target_e               target,
    input  logic [AREA_LSB-1:0]   area_off,
    output logic [AREA_LSB-1:0]   mem_offset
);

    localparam int ROM_LOG   = $clog2(ROM_BYTES);
    localparam int FLASH_LOG = $clog2(FLASH_BYTES);
    localparam int SRAM_LOG  = $clog2(SRAM_BYTES);

    logic [AREA_LSB-1:0] folded [MEM_COUNT];

    // One masked copy of the offset per memory.
    for (genvar g = 0; g < MEM_COUNT; g++) begin : g_fold
        localparam int SZ_LOG = (g == MEM_ROM)   ? ROM_LOG :
                                (g == MEM_FLASH) ? FLASH_LOG : SRAM_LOG;
        localparam logic [AREA_LSB-1:0] MASK =
            (SZ_LOG >= AREA_LSB) ? '1 : AREA_LSB'((1 << SZ_LOG) - 1);
        assign folded[g] = area_off & MASK;
    end

    // Pick the folded offset that belongs to the target.
    always_comb begin
        case (target)
            TGT_ROM:   mem_offset = folded[MEM_ROM];
            TGT_FLASH: mem_offset = folded[MEM_FLASH];
            TGT_SRAM:  mem_offset = folded[MEM_SRAM];
            default:   mem_offset = '0;
        endcase
    end

endmodule

// File: rtl/boot_alias_decoder.sv
// Module: boot_alias_decoder (top)
// Decodes the internal region into ROM/Flash/SRAM selects or an abort.
// Area 0 mirrors ROM or Flash (boot flag) or SRAM (remap).
// Assumes a synchronous active-low reset. Selects are combinational from the request.
module boot_alias_decoder
    import boot_map_pkg::*;
#(
    parameter int ADDR_W      = 28,
    parameter int DATA_W      = 32,
    parameter int CMD_BIT     = 0,
    parameter int ROM_BYTES   = 65536,
    parameter int FLASH_BYTES = 524288,
    parameter int SRAM_BYTES  = 32768
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                ctl_wr,
    input  logic [DATA_W-1:0]   ctl_wdata,
    input  logic                boot_sel_nv,
    input  logic                erase,
    output logic                sel_rom,
    output logic                sel_flash,
    output logic                sel_sram,
    output logic                abort,
    output logic [AREA_LSB-1:0] mem_offset
);

    logic    remap_q;
    logic    boot_q;
    target_e target;

    // State: remap toggle and boot flag.
    remap_state #(
        .DATA_W  (DATA_W),
        .CMD_BIT (CMD_BIT)
    ) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_wr      (ctl_wr),
        .ctl_wdata   (ctl_wdata),
        .boot_sel_nv (boot_sel_nv),
        .erase       (erase),
        .remap_q     (remap_q),
        .boot_q      (boot_q)
    );

    // Area decode.
    area_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .remap_q   (remap_q),
        .boot_q    (boot_q),
        .target    (target)
    );

    // Offset folding.
    offset_fold #(
        .ROM_BYTES   (ROM_BYTES),
        .FLASH_BYTES (FLASH_BYTES),
        .SRAM_BYTES  (SRAM_BYTES)
    ) u_fold (
        .target     (target),
        .area_off   (req_addr[AREA_LSB-1:0]),
        .mem_offset (mem_offset)
    );

    // Turn the target into one-hot outputs.
    assign sel_rom   = (target == TGT_ROM);
    assign sel_flash = (target == TGT_FLASH);
    assign sel_sram  = (target == TGT_SRAM);
    assign abort     = (target == TGT_ABORT);

endmodule

// File: rtl/boot_alias_checker.sv
// Module: boot_alias_checker
// Assertion checker bound to boot_alias_decoder.
// Assumes req_addr is known whenever req_valid is high.
module boot_alias_checker #(
    parameter int ADDR_W  = 28,
    parameter int DATA_W  = 32,
    parameter int CMD_BIT = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              ctl_wr,
    input logic [DATA_W-1:0] ctl_wdata,
    input logic              erase,
    input logic              sel_rom,
    input logic              sel_flash,
    input logic              sel_sram,
    input logic              abort,
    input logic [19:0]       mem_offset,
    input logic              remap_q,
    input logic              boot_q
);

    logic [ADDR_W-21:0] area_chk;
    logic               cmd_one;
    logic               unused_chk;

    assign area_chk   = req_addr[ADDR_W-1:20];
    assign cmd_one    = ctl_wr && ctl_wdata[CMD_BIT];
    assign unused_chk = ^ctl_wdata;

    AST_FIXED_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && area_chk == 1 |-> sel_flash);                             // R1
    AST_FIXED_SRAM: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && area_chk == 2 |-> sel_sram);                              // R1
    AST_FIXED_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && area_chk == 3 |-> sel_rom);                               // R1
    AST_UNMAPPED_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && area_chk > 3 |-> abort && mem_offset == '0);              // R2
    AST_BOOT_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && area_chk == 0 && !remap_q |-> (boot_q ? sel_flash : sel_rom)); // R3
    AST_ERASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> !boot_q);                                                    // R4
    AST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_one |=> remap_q != $past(remap_q));                                // R5
    AST_REMAP_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && area_chk == 0 && remap_q |-> sel_sram);                   // R5
    AST_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && !ctl_wdata[CMD_BIT] |=> $stable(remap_q));                   // R6
    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $countones({sel_rom, sel_flash, sel_sram, abort}) == 1); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !(sel_rom || sel_flash || sel_sram || abort) && mem_offset == '0); // R8

endmodule

bind boot_alias_decoder boot_alias_checker #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CMD_BIT (CMD_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (ctl_wdata),
    .erase      (erase),
    .sel_rom    (sel_rom),
    .sel_flash  (sel_flash),
    .sel_sram   (sel_sram),
    .abort      (abort),
    .mem_offset (mem_offset),
    .remap_q    (remap_q),
    .boot_q     (boot_q)
);

// File: tb/sim_boot_alias_decoder.sv
// Directed bench for boot_alias_decoder: one task per scenario.
module sim_boot_alias_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [27:0] req_addr = '0;
    logic        ctl_wr = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic        boot_sel_nv = 1'b0;
    logic        erase = 1'b0;
    logic        sel_rom, sel_flash, sel_sram, abort;
    logic [19:0] mem_offset;

    int checks = 0;
    int fails  = 0;

    // Expected target codes: 0 idle, 1 ROM, 2 Flash, 3 SRAM, 4 abort.
    localparam int E_IDLE = 0, E_ROM = 1, E_FLASH = 2, E_SRAM = 3, E_ABORT = 4;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_alias_decoder u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .boot_sel_nv(boot_sel_nv),
        .erase(erase), .sel_rom(sel_rom), .sel_flash(sel_flash),
        .sel_sram(sel_sram), .abort(abort), .mem_offset(mem_offset)
    );

    // Compare outputs with an expected target and offset.
    task automatic expect_out(input string req, input int tgt, input logic [19:0] off);
        logic [3:0] exp_v, act_v;
        exp_v = {tgt == E_ROM, tgt == E_FLASH, tgt == E_SRAM, tgt == E_ABORT};
        act_v = {sel_rom, sel_flash, sel_sram, abort};
        checks++;
        if (act_v !== exp_v || mem_offset !== off) begin
            fails++;
            $display("FAIL %s: sel{rom,flash,sram,abort}=%b off=%h, expected %b off=%h",
                     req, act_v, mem_offset, exp_v, off);
        end
    endtask

    // Present a request after a falling edge and check it before the next rising edge.
    task automatic probe(input string req, input logic [27:0] a, input int tgt,
                         input logic [19:0] off);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        #1;
        expect_out(req, tgt, off);
        req_valid = 1'b0;
    endtask

    // Reset sequence with a chosen boot-select value.
    task automatic do_reset(input logic boot);
        @(negedge clk);
        rst_n = 1'b0;
        boot_sel_nv = boot;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One-cycle write to the remap control register.
    task automatic ctl_write(input logic [31:0] d);
        @(negedge clk);
        ctl_wr = 1'b1;
        ctl_wdata = d;
        @(negedge clk);
        ctl_wr = 1'b0;
        ctl_wdata = '0;
    endtask

    // One-cycle erase strobe.
    task automatic pulse_erase();
        @(negedge clk);
        erase = 1'b1;
        @(negedge clk);
        erase = 1'b0;
    endtask

    // Reset state and idle behaviour.
    task automatic t_reset_idle();
        do_reset(1'b0);
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = 28'h00A_BCDE;
        #1;
        expect_out("R8 idle", E_IDLE, 20'h0);
        probe("R3 alias rom after reset", 28'h00A_BCDE, E_ROM, 20'h0BCDE);
    endtask

    // Fixed areas and offset folding.
    task automatic t_fixed_areas();
        probe("R1 flash area", 28'h012_3456, E_FLASH, 20'h23456);
        probe("R1 sram area",  28'h028_9ABC, E_SRAM,  20'h01ABC);
        probe("R1 rom area",   28'h034_5678, E_ROM,   20'h05678);
        probe("R7 flash top",  28'h01F_FFFF, E_FLASH, 20'h7FFFF);
    endtask

    // Unmapped areas.
    task automatic t_abort();
        probe("R2 first unmapped",  28'h040_0000, E_ABORT, 20'h0);
        probe("R2 middle unmapped", 28'h123_4567, E_ABORT, 20'h0);
        probe("R2 last unmapped",   28'hFFF_FFFF, E_ABORT, 20'h0);
    endtask

    // Remap toggling and zero-command writes.
    task automatic t_remap();
        ctl_write(32'h0000_0001);
        probe("R5 alias sram",           28'h00A_BCDE, E_SRAM,  20'h03CDE);
        probe("R1 rom fixed while remap", 28'h030_0010, E_ROM,  20'h00010);
        probe("R1 sram fixed while remap", 28'h020_0004, E_SRAM, 20'h00004);
        ctl_write(32'hFFFF_FFFE);
        probe("R6 zero cmd keeps remap", 28'h000_0000, E_SRAM,  20'h0);
        ctl_write(32'h0000_0001);
        probe("R5 second write restores", 28'h000_001C, E_ROM,  20'h0001C);
        ctl_write(32'h0000_0000);
        probe("R6 zero cmd keeps reset map", 28'h000_001C, E_ROM, 20'h0001C);
    endtask

    // Flash boot and erase.
    task automatic t_flash_boot();
        do_reset(1'b1);
        probe("R3 alias flash", 28'h00A_BCDE, E_FLASH, 20'h2BCDE);
        ctl_write(32'h1);
        pulse_erase();
        probe("R5 remap wins over boot", 28'h000_0020, E_SRAM, 20'h00020);
        ctl_write(32'h1);
        probe("R4 erase falls back to rom", 28'h00A_BCDE, E_ROM, 20'h0BCDE);
        do_reset(1'b1);
        pulse_erase();
        probe("R4 erase unremapped", 28'h000_0008, E_ROM, 20'h00008);
        probe("R1 flash fixed after erase", 28'h010_0008, E_FLASH, 20'h00008);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset_idle();
        t_fixed_areas();
        t_abort();
        t_remap();
        t_flash_boot();
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule